// File: doc/BRIEF.md
# Prescaled Saturating Charge Accumulator

This block is the digital back end of a battery charge counter. An analog integrator outside the block sends a tick each time its ramp reverses. Each tick is marked as charge (`tick_chg`) or discharge (`tick_dis`). A prescaler divides the ticks by a power of two, M. Each time the prescaler wraps upward or downward, a 16-bit accumulated count steps up or down by one. The count clamps at its limits and never wraps. A host can load it directly. An external charge-complete level can pin it at full scale. The count is compared against a programmable high limit and low limit, and the results drive two alert outputs.

A three-state controller sets the operating condition:
- `ST_RUN`: ticks are counted.
- `ST_SLEEP`: shutdown. Ticks are ignored and the prescaler residue is held at zero.
- `ST_FULL`: charge complete. The count is forced to FFFFh on every clock edge and ticks are ignored.

The controller is registered, so an input level takes effect one clock edge after it is sampled. It has these transitions:
- `GO_FULL`: from any state when `cc_mode` and `cc_in` are both high.
- `GO_SLEEP`: from any state when `shutdown` is high and `GO_FULL` does not apply.
- `GO_RUN`: from any state when neither of the above applies. This is how `ST_FULL` is left once `cc_in` falls.
- `STAY`: the state is kept whenever the inputs select the current state again.

Top module: `chg_accum`

## Requirements
- R1: After reset:
  - the count is 7FFFh;
  - the high limit is FFFFh and the low limit is 0000h, so both alerts are low;
  - the prescale code is 3'b111 (M = 128): 127 charge ticks leave the count unchanged and the 128th increments it;
  - `sat_flag` is low.
- R2: M equals 2 raised to the 3-bit prescale code, so M ranges from 1 to 128. The code is loaded from `wr_data[2:0]` when `wr_code_en` is high. A code write clears the prescaler residue and ignores any tick in the same cycle.
- R3: In `ST_RUN`, a charge tick raises the residue by one. When the residue already equals M−1, the tick wraps it to 0 and increments the count at that same clock edge. Starting from a cleared residue, the M-th charge tick increments the count.
- R4: In `ST_RUN`, a discharge tick lowers the residue by one. When the residue is 0, the tick wraps it to M−1 and decrements the count at that same clock edge. Apart from host writes and `ST_FULL`, the count moves by at most one per clock edge.
- R5: The count never wraps:
  - an increment at FFFFh leaves it at FFFFh;
  - a decrement at 0000h leaves it at 0000h;
  - `sat_flag` is high for exactly the one cycle after a clock edge at which a step was blocked.
- R6: When `cc_mode` and `cc_in` are both high at a clock edge, the controller enters `ST_FULL` at that edge. While in `ST_FULL`, each following edge sets the count to FFFFh and ticks have no effect. After `cc_in` is sampled low, the controller returns to `ST_RUN` and counting resumes from a cleared residue.
- R7: `alert_hi` is high exactly when the count is greater than the high limit. `alert_lo` is high exactly when the count is below the low limit. Both follow the registers in the same cycle.
- R8: When `shutdown` is high (and R6 does not apply), the controller enters `ST_SLEEP`. In `ST_SLEEP`, ticks are ignored and the residue is cleared, so the first charge tick after returning to `ST_RUN` starts a fresh group of M ticks.
- R9: Host writes load `wr_data` at the clock edge:
  - `wr_cnt_en` loads the count;
  - `wr_hi_en` loads the high limit;
  - `wr_lo_en` loads the low limit.
  A count write takes priority over a simultaneous tick and over `ST_FULL`, and it clears the prescaler residue.
- R10: A charge tick and a discharge tick in the same cycle cancel: the residue and the count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_chg | input | 1 | Integrator reversal, charge direction |
| tick_dis | input | 1 | Integrator reversal, discharge direction |
| shutdown | input | 1 | Level: ignore ticks and clear the residue |
| cc_mode | input | 1 | Level: enables the charge-complete input |
| cc_in | input | 1 | Level: battery full, pins the count at FFFFh |
| wr_code_en | input | 1 | Load the prescale code from wr_data[2:0] |
| wr_cnt_en | input | 1 | Load the count from wr_data |
| wr_hi_en | input | 1 | Load the high limit from wr_data |
| wr_lo_en | input | 1 | Load the low limit from wr_data |
| wr_data | input | 16 | Shared write data |
| count | output | 16 | Accumulated count |
| alert_hi | output | 1 | Count above the high limit |
| alert_lo | output | 1 | Count below the low limit |
| sat_flag | output | 1 | One-cycle pulse after a blocked step |

## Verification
The prescaler residue is never visible at the ports, so a fault in it shows up only as a count step that comes early, late or not at all. That step lands up to M ticks after the fault, which is 128 cycles with the default code. The bench therefore sweeps small codes, where a residue error surfaces within a few ticks, and it also runs the full default group. A wrong controller state shows up one edge after the triggering level: the count fails to jump to FFFFh, or ticks keep moving the count during shutdown. A missed clamp shows up at once, as a wrapped count and a missing `sat_flag` pulse.

// File: rtl/chgacc_pkg.sv
package chgacc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_FULL  = 2'd2
    } acc_state_t;
endpackage

// File: rtl/chgacc_ctrl.sv
module chgacc_ctrl
    import chgacc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shutdown,
    input  logic       cc_mode,
    input  logic       cc_in,
    output acc_state_t state,
    output logic       run,
    output logic       force_full
);
    acc_state_t state_nx;
    logic       full_req;

    assign full_req = cc_mode & cc_in;

    always_comb begin
        // GO_FULL has priority over GO_SLEEP, otherwise GO_RUN; STAY when unchanged
        if (full_req)      state_nx = ST_FULL;
        else if (shutdown) state_nx = ST_SLEEP;
        else               state_nx = ST_RUN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        run        = 1'b0;
        force_full = 1'b0;
        unique case (state)
            ST_RUN:   run        = 1'b1;
            ST_SLEEP: run        = 1'b0;
            ST_FULL:  force_full = 1'b1;
            default:  run        = 1'b0;
        endcase
    end

    // R6
    cc_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_mode && cc_in) |=> (state == ST_FULL));
    // R8
    sleep_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown && !(cc_mode && cc_in)) |=> (state == ST_SLEEP));
endmodule

// File: rtl/chgacc_prescaler.sv
module chgacc_prescaler #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clear,
    input  logic              wr_code_en,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              tick_up,
    input  logic              tick_dn,
    output logic              step_up,
    output logic              step_dn
);
    localparam int PW = (1 << CODE_W) - 1;

    logic [CODE_W-1:0] code;
    logic [PW-1:0]     resid, resid_nx, lim;
    logic              kill;

    // limit M-1 as a thermometer mask of 'code' ones
    always_comb begin
        for (int i = 0; i < PW; i++) begin
            lim[i] = (CODE_W'(i) < code);
        end
    end

    assign kill = clear | wr_code_en | ~run;

    always_comb begin
        resid_nx = resid;
        step_up  = 1'b0;
        step_dn  = 1'b0;
        if (kill) begin
            resid_nx = '0;
        end else if (tick_up ^ tick_dn) begin
            if (tick_up) begin
                if (resid >= lim) begin
                    resid_nx = '0;
                    step_up  = 1'b1;
                end else begin
                    resid_nx = resid + 1'b1;
                end
            end else begin
                if (resid == '0) begin
                    resid_nx = lim;
                    step_dn  = 1'b1;
                end else begin
                    resid_nx = resid - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code  <= '1;
            resid <= '0;
        end else begin
            if (wr_code_en) code <= wr_code;
            resid <= resid_nx;
        end
    end

    // R8
    residue_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (resid == '0));
    // R10
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!kill && tick_up && tick_dn) |=> $stable(resid));
    // R3
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |=> (resid == '0));
endmodule

// File: rtl/chgacc_counter.sv
module chgacc_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_cnt_en,
    input  logic         wr_hi_en,
    input  logic         wr_lo_en,
    input  logic [W-1:0] wr_data,
    input  logic         force_full,
    input  logic         step_up,
    input  logic         step_dn,
    output logic [W-1:0] count,
    output logic         alert_hi,
    output logic         alert_lo,
    output logic         sat_flag
);
    localparam logic [W-1:0] CMAX = '1;
    localparam logic [W-1:0] CMIN = '0;
    localparam logic [W-1:0] CMID = CMAX >> 1;

    logic [W-1:0] cnt_nx, thr_hi, thr_lo;
    logic         blocked;

    always_comb begin
        cnt_nx  = count;
        blocked = 1'b0;
        if (wr_cnt_en) begin
            cnt_nx = wr_data;
        end else if (force_full) begin
            cnt_nx = CMAX;
        end else if (step_up) begin
            if (count == CMAX) blocked = 1'b1;
            else               cnt_nx  = count + 1'b1;
        end else if (step_dn) begin
            if (count == CMIN) blocked = 1'b1;
            else               cnt_nx  = count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= CMID;
            thr_hi   <= CMAX;
            thr_lo   <= CMIN;
            sat_flag <= 1'b0;
        end else begin
            count    <= cnt_nx;
            sat_flag <= blocked;
            if (wr_hi_en) thr_hi <= wr_data;
            if (wr_lo_en) thr_lo <= wr_data;
        end
    end

    assign alert_hi = (count > thr_hi);
    assign alert_lo = (count < thr_lo);

    // R9
    write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_en |=> (count == $past(wr_data)));
    // R5
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt_en && !force_full && step_up && count == CMAX) |=> (count == CMAX && sat_flag));
    // R5
    sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt_en && !force_full && step_dn && count == CMIN) |=> (count == CMIN && sat_flag));
    // R6
    force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt_en && force_full) |=> (count == CMAX));
    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt_en && !force_full) |=>
            (count == $past(count) || count == $past(count) + 1'b1 || count == $past(count) - 1'b1));
endmodule

// File: rtl/chg_accum.sv
module chg_accum
    import chgacc_pkg::*;
#(
    parameter int W      = 16,
    parameter int CODE_W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_chg,
    input  logic         tick_dis,
    input  logic         shutdown,
    input  logic         cc_mode,
    input  logic         cc_in,
    input  logic         wr_code_en,
    input  logic         wr_cnt_en,
    input  logic         wr_hi_en,
    input  logic         wr_lo_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count,
    output logic         alert_hi,
    output logic         alert_lo,
    output logic         sat_flag
);
    acc_state_t state;
    logic       run, force_full, step_up, step_dn;

    chgacc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .shutdown   (shutdown),
        .cc_mode    (cc_mode),
        .cc_in      (cc_in),
        .state      (state),
        .run        (run),
        .force_full (force_full)
    );

    chgacc_prescaler #(.CODE_W(CODE_W)) u_pscl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .clear      (wr_cnt_en),
        .wr_code_en (wr_code_en),
        .wr_code    (wr_data[CODE_W-1:0]),
        .tick_up    (tick_chg),
        .tick_dn    (tick_dis),
        .step_up    (step_up),
        .step_dn    (step_dn)
    );

    chgacc_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cnt_en  (wr_cnt_en),
        .wr_hi_en   (wr_hi_en),
        .wr_lo_en   (wr_lo_en),
        .wr_data    (wr_data),
        .force_full (force_full),
        .step_up    (step_up),
        .step_dn    (step_dn),
        .count      (count),
        .alert_hi   (alert_hi),
        .alert_lo   (alert_lo),
        .sat_flag   (sat_flag)
    );

    // R6
    full_ignores_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |-> (!step_up && !step_dn));
endmodule

// File: tb/chg_accum_test.sv
module chg_accum_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_chg = 0, tick_dis = 0, shutdown = 0, cc_mode = 0, cc_in = 0;
    logic        wr_code_en = 0, wr_cnt_en = 0, wr_hi_en = 0, wr_lo_en = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        alert_hi, alert_lo, sat_flag;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model: 0 run, 1 sleep, 2 full
    int          m_st = 0;
    int          m_pre = 0, m_code = 7;
    logic [15:0] m_cnt = 16'h7FFF, m_hi = 16'hFFFF, m_lo = 16'h0000;
    bit          m_sat = 0;

    chg_accum uut (
        .clk(clk), .rst_n(rst_n), .tick_chg(tick_chg), .tick_dis(tick_dis),
        .shutdown(shutdown), .cc_mode(cc_mode), .cc_in(cc_in),
        .wr_code_en(wr_code_en), .wr_cnt_en(wr_cnt_en), .wr_hi_en(wr_hi_en),
        .wr_lo_en(wr_lo_en), .wr_data(wr_data), .count(count),
        .alert_hi(alert_hi), .alert_lo(alert_lo), .sat_flag(sat_flag)
    );

    always #2 clk = ~clk;

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int mlim(int code);
        return (1 << code) - 1;
    endfunction

    task automatic model_step();
        int  st_n = m_st, pre_n = m_pre;
        logic [15:0] cnt_n = m_cnt;
        bit  up = 0, dn = 0, sat_n = 0;
        if (cc_mode && cc_in) st_n = 2; else if (shutdown) st_n = 1; else st_n = 0;
        if (wr_cnt_en || wr_code_en || m_st != 0) pre_n = 0;
        else if (tick_chg != tick_dis) begin
            if (tick_chg) begin
                if (m_pre >= mlim(m_code)) begin pre_n = 0; up = 1; end
                else pre_n = m_pre + 1;
            end else begin
                if (m_pre == 0) begin pre_n = mlim(m_code); dn = 1; end
                else pre_n = m_pre - 1;
            end
        end
        if (wr_cnt_en) cnt_n = wr_data;
        else if (m_st == 2) cnt_n = 16'hFFFF;
        else if (up) begin if (m_cnt == 16'hFFFF) sat_n = 1; else cnt_n = m_cnt + 1; end
        else if (dn) begin if (m_cnt == 16'h0000) sat_n = 1; else cnt_n = m_cnt - 1; end
        if (wr_code_en) m_code = int'(wr_data[2:0]);
        if (wr_hi_en) m_hi = wr_data;
        if (wr_lo_en) m_lo = wr_data;
        m_st = st_n; m_pre = pre_n; m_cnt = cnt_n; m_sat = sat_n;
    endtask

    task automatic compare(string tag);
        bit eh = (m_cnt > m_hi), el = (m_cnt < m_lo);
        checks++;
        if (count !== m_cnt || alert_hi !== eh || alert_lo !== el || sat_flag !== m_sat) begin
            errors++;
            $display("FAIL %s: cnt=%h hi=%b lo=%b sat=%b expected cnt=%h hi=%b lo=%b sat=%b",
                     tag, count, alert_hi, alert_lo, sat_flag, m_cnt, eh, el, m_sat);
        end
    endtask

    // inputs already set at a negedge; advance one edge and compare
    task automatic cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        tick_chg = 0; tick_dis = 0;
        wr_code_en = 0; wr_cnt_en = 0; wr_hi_en = 0; wr_lo_en = 0;
    endtask

    task automatic wr_cnt(logic [15:0] v, string tag);
        wr_cnt_en = 1; wr_data = v; cyc(tag);
    endtask
    task automatic wr_code(int c, string tag);
        wr_code_en = 1; wr_data = 16'(c); cyc(tag);
    endtask
    task automatic ticks(int n, bit chg, string tag);
        for (int i = 0; i < n; i++) begin
            tick_chg = chg; tick_dis = !chg; cyc(tag);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare("R1 reset state");
        // R1: default M=128
        ticks(127, 1, "R1 default group");
        ticks(1, 1, "R1 128th tick");
        // R2/R3: M=4
        wr_code(2, "R2 code write");
        ticks(3, 1, "R3 partial group");
        ticks(1, 1, "R3 wrap up");
        // R4: discharge from zero residue decrements at once
        ticks(1, 0, "R4 discharge wrap");
        ticks(3, 0, "R4 residue down");
        ticks(1, 0, "R4 second decrement");
        // R5: saturation at top and bottom, M=1
        wr_code(0, "R2 code M=1");
        wr_cnt(16'hFFFE, "R9 count write");
        ticks(3, 1, "R5 clamp top");
        cyc("R5 sat pulse ends");
        wr_cnt(16'h0001, "R9 count write low");
        ticks(3, 0, "R5 clamp bottom");
        cyc("R5 sat pulse ends");
        // R9: write priority over tick, clears residue
        wr_code(3, "R2 code M=8");
        ticks(5, 1, "R3 build residue");
        tick_chg = 1; wr_cnt_en = 1; wr_data = 16'h1234; cyc("R9 write beats tick");
        ticks(8, 1, "R9 residue cleared");
        // R10: cancel
        tick_chg = 1; tick_dis = 1; cyc("R10 cancel");
        ticks(7, 1, "R10 residue kept");
        // R7: thresholds
        wr_hi_en = 1; wr_data = 16'h1234; cyc("R7 high limit");
        wr_lo_en = 1; wr_data = 16'h1236; cyc("R7 low limit");
        ticks(8, 1, "R7 cross high");
        wr_hi_en = 1; wr_lo_en = 1; wr_data = 16'h1235; cyc("R7 both limits equal");
        // R8: shutdown
        ticks(4, 1, "R8 residue before sleep");
        shutdown = 1;
        ticks(20, 1, "R8 ticks ignored");
        shutdown = 0;
        cyc("R8 wake");
        ticks(8, 1, "R8 fresh group");
        // R6: charge complete
        cc_mode = 1; cc_in = 1;
        ticks(5, 0, "R6 force full");
        wr_cnt_en = 1; wr_data = 16'h0100; cyc("R9 write in full");
        cyc("R6 re-forced");
        cc_in = 0;
        ticks(10, 0, "R6 resume counting");
        cc_mode = 0; cc_in = 1;
        ticks(3, 0, "R6 input masked when mode off");
        cc_in = 0;
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r = int'($urandom_range(0, 99));
            tick_chg = ($urandom_range(0, 2) == 0);
            tick_dis = ($urandom_range(0, 2) == 0);
            shutdown = ($urandom_range(0, 40) == 0);
            cc_mode  = ($urandom_range(0, 3) == 0);
            cc_in    = ($urandom_range(0, 30) == 0);
            if (r < 2) begin wr_code_en = 1; wr_data = 16'($urandom_range(0, 3)); end
            else if (r < 4) begin
                wr_cnt_en = 1;
                wr_data = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(0, 3))
                                                      : 16'($urandom_range(16'hFFFC, 16'hFFFF));
            end
            else if (r < 5) begin wr_hi_en = 1; wr_data = 16'($urandom); end
            else if (r < 6) begin wr_lo_en = 1; wr_data = 16'($urandom); end
            cyc("R3 R4 R5 R6 R8 R10 random mix");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule